// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers twelve interrupt request lines, picks the most urgent one that is allowed to run, and presents its fixed vector address to a program sequencer together with a request strobe. Line 0 is a warm-restart request and line 1 a powerdown request. Neither can be masked. Lines 2 to 11 are maskable: three of them are external pins that can each be set to edge or level sensing, and the rest come from on-chip peripherals. Software reaches a mask register, a control register, a global enable flag and a write-only force/clear register through a small register write/read port.

When the sequencer accepts the presented interrupt, the controller does three things on that clock edge. It clears any edge or force latch held by that source. It marks the source as in service. It pushes the sequencer's 25-bit status word onto a twelve-entry stack. A return strobe releases the most urgent source in service and pops the stack. With nesting enabled, only strictly more urgent sources can interrupt a running service routine. With nesting disabled, nothing but a restart is presented until the routine returns.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Urgency runs from line 0 (highest) to line 11 (lowest). The vectors are: line 0 → 0x0000, line 1 → 0x002C, and line s for s = 2..11 → 4·(s−1), which gives 0x0004 for line 2 up to 0x0028 for line 11. `irq_req_o` is high whenever any line is eligible, and `irq_vec_o` then carries the vector of the most urgent eligible line.
- R2: The mask register is at address 0. Its bit m (m = 0..9) enables line m+2. It resets to zero, so no maskable line is presented after reset. Lines 0 and 1 ignore the mask.
- R3: The global enable is bit 0 at address 3 and resets to 1. While it is 0, every line except line 0 is withheld, whatever the mask holds, and this includes the powerdown line.
- R4: The control register is at address 1. Bit 0 selects edge sensing for line 10, bit 1 for line 9 and bit 2 for line 2 (1 = edge, 0 = level). Bit 4 enables nesting. It resets to zero, and bit 3 always reads as 0.
- R5: An edge-sensing line is latched on a rising input edge and becomes pending on the cycle after the edge. It stays pending after the pin falls, until it is accepted or cleared. Every other line is pending only while its input is high.
- R6: A write to address 2 acts on eight lines, where bit k (k = 0..7) refers to line 2 for k = 0 and to line k+4 otherwise. Bit 8+k sets a force latch that makes the line pending. Bit k clears that line's force latch and its edge latch. Reads of address 2 return 0.
- R7: An `irq_ack_i` high while `irq_req_o` is high accepts the presented line and clears that line's edge and force latches on the same edge. An acknowledge with no request present changes nothing.
- R8: With nesting disabled, once a line has been accepted no line other than line 0 is presented until `irq_rti_i` is pulsed.
- R9: With nesting enabled, while lines are in service only strictly more urgent lines (and line 0) are presented. A return releases the most urgent line in service, which restores the level that was in effect before it.
- R10: Each accept pushes `stat_i`, and `stat_top_o` shows the newest entry from the next cycle on. A return pops the stack. `stat_top_o` is 0 when the stack is empty.
- R11: A push onto a full stack (12 entries) sets `stk_ovf_o`, and a pop from an empty stack sets `stk_unf_o`. In both cases the stack contents are left unchanged. Both flags stay set until reset.
- R12: A return strobe in the same cycle as an accepted acknowledge is ignored, so the stack gains one entry and nothing is popped.
- R13: Addresses 0, 1 and 3 read back the stored mask, control and global-enable values, zero-extended to 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_raw_i | input | 12 | Raw request lines, index 0 most urgent |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for `reg_addr_i` (combinational) |
| irq_req_o | output | 1 | An eligible interrupt is presented |
| irq_vec_o | output | 14 | Vector address of the presented interrupt |
| irq_ack_i | input | 1 | Sequencer accepts the presented interrupt |
| irq_rti_i | input | 1 | Sequencer returns from a service routine |
| stat_i | input | 25 | Status word to save on accept |
| stat_top_o | output | 25 | Newest saved status word, 0 when empty |
| stk_ovf_o | output | 1 | Sticky stack overflow flag |
| stk_unf_o | output | 1 | Sticky stack underflow flag |

## Verification
A stuck or missing edge or force latch shows at `irq_req_o` on the cycle after the pin edge or register write that should have moved it. It also shows after an accept-and-return pair, where a stale latch presents a request again. A wrong in-service record shows up as soon as any other line is raised: a vector that should have been withheld appears, or a vector that should appear is withheld. A wrong stack count or entry shows at `stat_top_o`, or in the sticky flags, one cycle after the push or pop that corrupted it.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;

    localparam int NUM_SRC        = 12;
    localparam int NUM_MASKABLE   = 10;
    localparam int FIRST_MASKABLE = NUM_SRC - NUM_MASKABLE;
    localparam int NUM_FC         = 8;

    localparam int SRC_RESTART = 0;
    localparam int SRC_PWRDN   = 1;
    localparam int SRC_PIN2    = 2;
    localparam int SRC_PIN1    = 9;
    localparam int SRC_PIN0    = 10;

    localparam int CTL_W    = 5;
    localparam int CTL_NEST = 4;
    localparam logic [CTL_W-1:0] CTL_KEEP = 5'b10111;

    localparam int REG_AW = 2;
    localparam int REG_DW = 16;

    typedef enum logic [REG_AW-1:0] {
        RA_MASK   = 2'd0,
        RA_CTL    = 2'd1,
        RA_FRCCLR = 2'd2,
        RA_GIE    = 2'd3
    } reg_addr_e;

    localparam logic [15:0] PWRDN_VEC = 16'h002C;

    typedef struct packed {
        logic [NUM_MASKABLE-1:0] mask;
        logic [CTL_W-1:0]        ctl;
        logic                    gie;
        logic [NUM_SRC-1:0]      svc;
    } regs_t;

    // force/clear bit k -> request line
    function automatic int unsigned fc_src(input int unsigned k);
        return (k == 0) ? SRC_PIN2 : k + 4;
    endfunction

    function automatic logic [15:0] vec_of(input int unsigned s);
        if (s == SRC_RESTART)    return 16'h0000;
        else if (s == SRC_PWRDN) return PWRDN_VEC;
        else                     return 16'((s - 1) * 4);
    endfunction

endpackage

// File: rtl/prio_irq_pending.sv
`timescale 1ns/1ps
module prio_irq_pending
    import prio_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] edge_mode_i,
    input  logic [N-1:0] frc_set_i,
    input  logic [N-1:0] frc_clr_i,
    input  logic [N-1:0] acc_clr_i,
    output logic [N-1:0] pend_o
);

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] edg;
        logic [N-1:0] frc;
    } pend_st_t;

    pend_st_t st_d, st_q;
    logic [N-1:0] rise;

    always_comb begin
        rise      = raw_i & ~st_q.prev;
        st_d.prev = raw_i;
        // a new edge wins over a clear in the same cycle
        st_d.edg  = (edge_mode_i & rise)
                  | (st_q.edg & edge_mode_i & ~acc_clr_i & ~frc_clr_i);
        st_d.frc  = frc_set_i | (st_q.frc & ~acc_clr_i & ~frc_clr_i);
        pend_o    = (edge_mode_i & st_q.edg) | (~edge_mode_i & raw_i) | st_q.frc;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/prio_irq_select.sv
`timescale 1ns/1ps
module prio_irq_select
    import prio_irq_pkg::*;
#(
    parameter int N     = NUM_SRC,
    parameter int VEC_W = 14,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]            pend_i,
    input  logic [NUM_MASKABLE-1:0] mask_i,
    input  logic                    gie_i,
    input  logic                    nest_i,
    input  logic [N-1:0]            svc_i,
    output logic                    req_o,
    output logic [IW-1:0]           idx_o,
    output logic [N-1:0]            onehot_o,
    output logic [VEC_W-1:0]        vec_o
);

    logic [N-1:0] en, hold, elig;
    logic         seen;
    logic [15:0]  vec_full;

    always_comb begin
        en   = {mask_i, {FIRST_MASKABLE{1'b1}}};
        seen = 1'b0;
        for (int s = 0; s < N; s++) begin
            seen    = seen | svc_i[s];
            hold[s] = (s == SRC_RESTART) ? 1'b0
                    : (~gie_i | (nest_i ? seen : (svc_i != '0)));
        end
        elig     = pend_i & en & ~hold;
        onehot_o = elig & (~elig + 1'b1);
        req_o    = |elig;
        idx_o    = '0;
        for (int s = N - 1; s >= 0; s--) begin
            if (elig[s]) idx_o = IW'(s);
        end
        vec_full = vec_of(int'(idx_o));
        vec_o    = VEC_W'(vec_full);
    end

endmodule

// File: rtl/prio_irq_stack.sv
`timescale 1ns/1ps
module prio_irq_stack #(
    parameter int DEPTH = 12,
    parameter int W     = 25,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [W-1:0]  data_i,
    output logic [W-1:0]  top_o,
    output logic          ovf_o,
    output logic          unf_o,
    output logic [CW-1:0] cnt_o
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
        logic                    ovf;
        logic                    unf;
    } stk_st_t;

    stk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i) begin
            if (st_q.cnt == CW'(DEPTH)) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.mem[AW'(st_q.cnt)] = data_i;
                st_d.cnt                = st_q.cnt + 1'b1;
            end
        end else if (pop_i) begin
            if (st_q.cnt == '0) st_d.unf = 1'b1;
            else                st_d.cnt = st_q.cnt - 1'b1;
        end
        top_o = (st_q.cnt == '0) ? '0 : st_q.mem[AW'(st_q.cnt - 1'b1)];
        ovf_o = st_q.ovf;
        unf_o = st_q.unf;
        cnt_o = st_q.cnt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int STK_DEPTH = 12,
    parameter int STAT_W    = 25,
    parameter int VEC_W     = 14
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] irq_raw_i,
    input  logic               reg_wr_i,
    input  logic [REG_AW-1:0]  reg_addr_i,
    input  logic [REG_DW-1:0]  reg_wdata_i,
    output logic [REG_DW-1:0]  reg_rdata_o,
    output logic               irq_req_o,
    output logic [VEC_W-1:0]   irq_vec_o,
    input  logic               irq_ack_i,
    input  logic               irq_rti_i,
    input  logic [STAT_W-1:0]  stat_i,
    output logic [STAT_W-1:0]  stat_top_o,
    output logic               stk_ovf_o,
    output logic               stk_unf_o
);

    localparam int IW = $clog2(NUM_SRC);
    localparam int CW = $clog2(STK_DEPTH + 1);

    regs_t              r_d, r_q;
    logic [NUM_SRC-1:0] edge_mode, frc_set, frc_clr, acc_clr, pend, sel_onehot;
    logic [IW-1:0]      sel_idx;
    logic               acc, wr_frc;
    logic [CW-1:0]      stk_cnt;

    always_comb begin
        acc    = irq_ack_i & irq_req_o;
        wr_frc = reg_wr_i && (reg_addr_e'(reg_addr_i) == RA_FRCCLR);

        edge_mode           = '0;
        edge_mode[SRC_PIN0] = r_q.ctl[0];
        edge_mode[SRC_PIN1] = r_q.ctl[1];
        edge_mode[SRC_PIN2] = r_q.ctl[2];

        frc_set = '0;
        frc_clr = '0;
        for (int k = 0; k < NUM_FC; k++) begin
            frc_set[fc_src(k)] = wr_frc & reg_wdata_i[NUM_FC + k];
            frc_clr[fc_src(k)] = wr_frc & reg_wdata_i[k];
        end
        acc_clr = acc ? sel_onehot : '0;

        r_d = r_q;
        if (reg_wr_i) begin
            case (reg_addr_e'(reg_addr_i))
                RA_MASK: r_d.mask = reg_wdata_i[NUM_MASKABLE-1:0];
                RA_CTL:  r_d.ctl  = reg_wdata_i[CTL_W-1:0] & CTL_KEEP;
                RA_GIE:  r_d.gie  = reg_wdata_i[0];
                default: ;
            endcase
        end
        if (acc)            r_d.svc = r_q.svc | sel_onehot;
        else if (irq_rti_i) r_d.svc = r_q.svc & (r_q.svc - 1'b1);

        case (reg_addr_e'(reg_addr_i))
            RA_MASK: reg_rdata_o = REG_DW'(r_q.mask);
            RA_CTL:  reg_rdata_o = REG_DW'(r_q.ctl);
            RA_GIE:  reg_rdata_o = REG_DW'(r_q.gie);
            default: reg_rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '{mask: '0, ctl: '0, gie: 1'b1, svc: '0};
        else         r_q <= r_d;
    end

    prio_irq_pending #(.N(NUM_SRC)) u_pend (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .raw_i       (irq_raw_i),
        .edge_mode_i (edge_mode),
        .frc_set_i   (frc_set),
        .frc_clr_i   (frc_clr),
        .acc_clr_i   (acc_clr),
        .pend_o      (pend)
    );

    prio_irq_select #(.N(NUM_SRC), .VEC_W(VEC_W)) u_sel (
        .pend_i   (pend),
        .mask_i   (r_q.mask),
        .gie_i    (r_q.gie),
        .nest_i   (r_q.ctl[CTL_NEST]),
        .svc_i    (r_q.svc),
        .req_o    (irq_req_o),
        .idx_o    (sel_idx),
        .onehot_o (sel_onehot),
        .vec_o    (irq_vec_o)
    );

    prio_irq_stack #(.DEPTH(STK_DEPTH), .W(STAT_W)) u_stk (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (acc),
        .pop_i  (irq_rti_i & ~acc),
        .data_i (stat_i),
        .top_o  (stat_top_o),
        .ovf_o  (stk_ovf_o),
        .unf_o  (stk_unf_o),
        .cnt_o  (stk_cnt)
    );

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module prio_irq_ctrl_chk #(
    parameter int DEPTH  = 12,
    parameter int VEC_W  = 14,
    parameter int STAT_W = 25,
    parameter int NS     = 12,
    parameter int NM     = 10,
    parameter int CW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic [VEC_W-1:0]  vec,
    input logic              ack,
    input logic              rti,
    input logic [NM-1:0]     mask,
    input logic              nest,
    input logic              gie,
    input logic [NS-1:0]     svc,
    input logic [CW-1:0]     cnt,
    input logic [STAT_W-1:0] stat_in,
    input logic [STAT_W-1:0] stat_top,
    input logic              ovf,
    input logic              unf
);

    logic [3:0]    vidx;
    logic [NS-1:0] at_or_above;

    always_comb begin
        if (vec == '0)                  vidx = 4'd0;
        else if (vec == VEC_W'(16'h2C)) vidx = 4'd1;
        else                            vidx = 4'(vec[5:2]) + 4'd1;
        at_or_above = (NS'(2) << vidx) - 1'b1;
    end

    p_mask_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && vidx >= 4'd2) |-> mask[vidx - 4'd2]);

    p_gie_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gie) |-> (vec == '0));

    p_single_svc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !nest && svc != '0) |-> (vec == '0));

    p_only_higher_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && nest && vidx != 4'd0) |-> ((svc & at_or_above) == '0));

    p_push_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req && cnt < CW'(DEPTH)) |=> (stat_top == $past(stat_in)));

    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    p_unf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> unf);

    p_rti_with_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req && rti && cnt < CW'(DEPTH)) |=> (cnt == $past(cnt) + 1'b1));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .DEPTH(STK_DEPTH), .VEC_W(VEC_W), .STAT_W(STAT_W),
    .NS(prio_irq_pkg::NUM_SRC), .NM(prio_irq_pkg::NUM_MASKABLE), .CW(CW)
) u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .req      (irq_req_o),
    .vec      (irq_vec_o),
    .ack      (irq_ack_i),
    .rti      (irq_rti_i),
    .mask     (r_q.mask),
    .nest     (r_q.ctl[prio_irq_pkg::CTL_NEST]),
    .gie      (r_q.gie),
    .svc      (r_q.svc),
    .cnt      (stk_cnt),
    .stat_in  (stat_i),
    .stat_top (stat_top_o),
    .ovf      (stk_ovf_o),
    .unf      (stk_unf_o)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] raw = '0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        req;
    logic [13:0] vec;
    logic        ack = 1'b0;
    logic        rti = 1'b0;
    logic [24:0] stat = '0;
    logic [24:0] top;
    logic        ovf, unf;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .irq_raw_i(raw),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_req_o(req), .irq_vec_o(vec), .irq_ack_i(ack), .irq_rti_i(rti),
        .stat_i(stat), .stat_top_o(top), .stk_ovf_o(ovf), .stk_unf_o(unf)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(); @(posedge clk); @(negedge clk); endtask
    task automatic settle(); #2; endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        wr = 1'b1; addr = a; wdata = d; tick(); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
        addr = a; settle(); d = rdata;
    endtask

    task automatic accept(input logic [24:0] s);
        stat = s; ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic ret(); rti = 1'b1; tick(); rti = 1'b0; endtask

    task automatic t_reset();
        logic [15:0] d;
        settle();
        check("R2", "req after reset", req, 0);
        rd_reg(2'd0, d); check("R13", "mask reset", d, 0);
        rd_reg(2'd1, d); check("R4", "ctl reset", d, 0);
        rd_reg(2'd3, d); check("R3", "gie reset", d, 1);
        check("R11", "ovf reset", ovf, 0);
        check("R11", "unf reset", unf, 0);
        check("R10", "top empty", top, 0);
        raw = 12'h008; settle();
        check("R2", "masked line withheld", req, 0);
        raw = '0;
    endtask

    task automatic t_regs();
        logic [15:0] d;
        wr_reg(2'd0, 16'hFFFF); rd_reg(2'd0, d); check("R13", "mask readback", d, 16'h03FF);
        wr_reg(2'd1, 16'hFFFF); rd_reg(2'd1, d); check("R4", "ctl readback bit3 zero", d, 16'h0017);
        wr_reg(2'd3, 16'h0000); rd_reg(2'd3, d); check("R13", "gie readback", d, 0);
        wr_reg(2'd3, 16'h0001);
        wr_reg(2'd1, 16'h0000);
        wr_reg(2'd0, 16'h0000);
    endtask

    task automatic t_priority();
        wr_reg(2'd0, 16'h03FF);
        for (int s = 2; s < 12; s++) begin
            raw = 12'(1 << s); settle();
            check("R1", $sformatf("req line %0d", s), req, 1);
            check("R1", $sformatf("vec line %0d", s), vec, 32'((s - 1) * 4));
        end
        raw = 12'h808; settle(); check("R1", "line3 over line11", vec, 14'h008);
        raw = 12'h80A; settle(); check("R1", "powerdown over line3", vec, 14'h02C);
        raw = 12'h80B; settle(); check("R1", "restart over all", vec, 14'h000);
        check("R1", "restart req", req, 1);
        raw = '0; settle(); check("R1", "idle no req", req, 0);
        wr_reg(2'd0, 16'h0000);
    endtask

    task automatic t_mask();
        wr_reg(2'd0, 16'h0008);
        raw = 12'h030; settle(); check("R2", "only line5 enabled", vec, 14'h010);
        raw = 12'h010; settle(); check("R2", "line4 masked", req, 0);
        wr_reg(2'd0, 16'h0000);
        raw = 12'h002; settle(); check("R2", "powerdown unmaskable", vec, 14'h02C);
        check("R2", "powerdown req", req, 1);
        raw = '0;
    endtask

    task automatic t_gie();
        wr_reg(2'd3, 16'h0000);
        raw = 12'h002; settle(); check("R3", "powerdown blocked", req, 0);
        raw = 12'h003; settle(); check("R3", "restart passes", req, 1);
        check("R3", "restart vec", vec, 0);
        raw = '0;
        wr_reg(2'd3, 16'h0001);
        raw = 12'h002; settle(); check("R3", "powerdown after enable", vec, 14'h02C);
        raw = '0;
    endtask

    task automatic t_edge();
        wr_reg(2'd1, 16'h0004);
        wr_reg(2'd0, 16'h0001);
        raw[2] = 1'b1; settle(); check("R5", "edge not yet latched", req, 0);
        tick(); settle(); check("R5", "edge latched", vec, 14'h004);
        check("R4", "line2 edge req", req, 1);
        raw[2] = 1'b0; tick(); settle(); check("R5", "latch held after pin low", req, 1);
        wr_reg(2'd2, 16'h0001); settle(); check("R6", "clear bit0 drops line2", req, 0);
        wr_reg(2'd1, 16'h0000);
        raw[2] = 1'b1; settle(); check("R5", "level pending", req, 1);
        raw[2] = 1'b0; settle(); check("R5", "level released", req, 0);
        wr_reg(2'd1, 16'h0001);
        wr_reg(2'd0, 16'h0100);
        raw[10] = 1'b1; tick(); raw[10] = 1'b0; tick(); settle();
        check("R4", "ctl bit0 edge on line10", vec, 14'h024);
        check("R4", "line10 held", req, 1);
        wr_reg(2'd2, 16'h0040); settle(); check("R6", "clear bit6 drops line10", req, 0);
        wr_reg(2'd1, 16'h0000);
        wr_reg(2'd0, 16'h0000);
    endtask

    task automatic t_force();
        logic [15:0] d;
        wr_reg(2'd0, 16'h03FF);
        wr_reg(2'd2, 16'h8000); settle(); check("R6", "force bit15 line11", vec, 14'h028);
        check("R6", "forced req", req, 1);
        rd_reg(2'd2, d); check("R6", "force/clear reads zero", d, 0);
        wr_reg(2'd2, 16'h0080); settle(); check("R6", "clear bit7", req, 0);
        wr_reg(2'd2, 16'h0200); settle(); check("R6", "force bit9 line5", vec, 14'h010);
        accept(25'h11); settle(); check("R8", "in service blocks", req, 0);
        ret(); settle(); check("R7", "accept cleared force latch", req, 0);
        check("R10", "stack back empty", top, 0);
        wr_reg(2'd0, 16'h0000);
    endtask

    task automatic t_ack_idle();
        accept(25'h1234); settle();
        check("R7", "idle ack no push", top, 0);
        check("R7", "idle ack no ovf", ovf, 0);
        wr_reg(2'd0, 16'h03FF);
        raw = 12'h040; settle(); check("R7", "idle ack left no service", vec, 14'h014);
        raw = '0;
        wr_reg(2'd0, 16'h0000);
    endtask

    task automatic t_no_nest();
        wr_reg(2'd0, 16'h03FF);
        raw = 12'h800; settle(); check("R1", "timer presented", vec, 14'h028);
        accept(25'h1AAAA);
        raw = 12'h804; settle(); check("R8", "higher line held off", req, 0);
        check("R10", "pushed status", top, 25'h1AAAA);
        ret(); settle();
        check("R10", "popped status", top, 0);
        check("R8", "after return line2 presented", vec, 14'h004);
        raw = '0;
        wr_reg(2'd0, 16'h0000);
    endtask

    task automatic t_nest();
        wr_reg(2'd1, 16'h0010);
        wr_reg(2'd0, 16'h03FF);
        raw = 12'h100; settle(); check("R9", "line8 presented", vec, 14'h01C);
        accept(25'h0AAAA);
        raw = 12'h900; settle(); check("R9", "equal/lower held", req, 0);
        raw = 12'h920; settle(); check("R9", "higher line5 presented", vec, 14'h010);
        accept(25'h0BBBB); settle();
        check("R10", "nested top", top, 25'h0BBBB);
        raw = 12'h924; settle(); check("R9", "line2 preempts", vec, 14'h004);
        raw = 12'h820; ret(); settle();
        check("R9", "level restored to line8", vec, 14'h010);
        check("R10", "outer status back", top, 25'h0AAAA);
        raw = '0; ret();
        raw = 12'h800; settle(); check("R9", "all released", vec, 14'h028);
        raw = '0;
        wr_reg(2'd1, 16'h0000);
        wr_reg(2'd0, 16'h0000);
    endtask

    task automatic t_same_cycle();
        wr_reg(2'd0, 16'h03FF);
        raw = 12'h008;
        stat = 25'h0C0DE; ack = 1'b1; rti = 1'b1; tick(); ack = 1'b0; rti = 1'b0;
        settle();
        check("R12", "push kept", top, 25'h0C0DE);
        check("R12", "no underflow", unf, 0);
        check("R12", "line3 in service", req, 0);
        ret(); settle();
        check("R12", "pop after", top, 0);
        check("R12", "line3 again", vec, 14'h008);
        raw = '0;
        wr_reg(2'd0, 16'h0000);
    endtask

    task automatic t_overflow();
        raw = 12'h001; ack = 1'b1;
        for (int i = 1; i <= 13; i++) begin
            stat = 25'h100 + 25'(i); tick();
        end
        ack = 1'b0; raw = '0; settle();
        check("R11", "overflow set", ovf, 1);
        check("R11", "full top unchanged", top, 25'h10C);
        ret(); settle(); check("R11", "pop after overflow", top, 25'h10B);
        for (int i = 0; i < 11; i++) ret();
        settle();
        check("R11", "emptied", top, 0);
        check("R11", "no underflow yet", unf, 0);
        ret(); settle();
        check("R11", "underflow set", unf, 1);
        check("R11", "overflow sticky", ovf, 1);
        check("R11", "empty top stays", top, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_priority();
        t_mask();
        t_gie();
        t_edge();
        t_force();
        t_ack_idle();
        t_no_nest();
        t_nest();
        t_same_cycle();
        t_overflow();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule